// File: doc/BRIEF.md
# SPI Slave Boot Loader with Host Wait

This block receives a boot image from an external SPI master while acting as the slave. Incoming bytes pass through a four-entry receive queue. A single consumer drains the queue. It assembles a ten-byte header that gives a destination address, a byte count and a flag word, and then writes that many payload bytes to consecutive memory addresses. After the payload it expects the next header. Any number of blocks may follow one another.

The master cannot see how full the queue is. The block therefore raises a host-wait flag on one line of a general-purpose output bank. The flag rises when the queue is close to full and drops once the queue has drained. Each header's flag word selects which output line carries the flag. Until the first flag word arrives, line 0 carries it. The consumer is gated by the memory port's ready input, so a memory stall holds bytes in the queue and makes the wait flag rise.

Top module: `spi_boot_rx`

## Requirements
- R1: While `cs_n` is low, one bit of `mosi` is sampled on each rising edge of `sck`, most significant bit first, and every eighth bit completes a byte. `sck` edges while `cs_n` is high have no effect.
- R2: Raising `cs_n` clears the bit counter. A partial byte is discarded, and the next byte starts fresh after `cs_n` falls again.
- R3: The receive queue holds 4 bytes. A byte that completes while the queue is full is dropped. Bytes that arrive while the wait flag is high are still stored if there is room. A drop sets `ovf_err`, which stays set until reset.
- R4: The wait flag rises when the queue level reaches 3. It stays high until the level falls to 1 or less. A level of 2 does not change the flag in either direction.
- R5: The output bank `gpo` is active high. While the flag is high, exactly one bit is set. While the flag is low, all bits are 0.
- R6: The line that carries the flag is given by bits 10:5 of the header's 16-bit flag word. The other flag bits have no effect. Before the first flag word is complete, line 0 is used.
- R7: The header is 10 bytes in this order: the destination address as 4 bytes with the least significant byte first, then the byte count as 4 bytes with the least significant byte first, then the flag word as 2 bytes with the least significant byte first.
- R8: After a header with count N, the next N queued bytes are written to addresses dest, dest+1, … (wrapping modulo 2^32). The byte after them starts a new header.
- R9: A header with count 0 produces no memory write, and the next byte is a header byte.
- R10: The consumer takes at most one byte per clock, and only while `mem_rdy` is high. `mem_we` stays asserted with `mem_addr` and `mem_data` unchanged until a cycle with `mem_rdy` high accepts the byte.
- R11: After reset, `gpo` is 0, `mem_we` is 0, `ovf_err` is 0 and the flag line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock from the master |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from the master |
| mem_rdy | input | 1 | Memory accepts a write this cycle |
| gpo | output | NPIN | Output bank carrying the host-wait flag |
| mem_we | output | 1 | Payload byte valid for memory |
| mem_addr | output | 32 | Payload byte address |
| mem_data | output | 8 | Payload byte |
| ovf_err | output | 1 | Sticky queue overflow indication |

## Verification
The bench stalls memory so the queue fills byte by byte. It then releases the stall one cycle at a time, checking that the flag rises at a level of 3 and not at 2, and that it stays high at 2 on the way down. A design without this hysteresis would chatter or release too early. It sends a fifth byte into a full queue and checks that exactly that byte is missing from memory and that the error stays set. A design that overwrote a queue entry would corrupt an earlier byte. The table of blocks includes a zero count, a single byte, an address that wraps through zero, and flag words with junk outside bits 10:5. A decoder that shifted the pin field or mishandled a zero count would drive the wrong line or lose stream alignment. A chip select pulse in the middle of a byte checks that a stale bit count does not shift every later byte.

// File: rtl/spi_boot_rx.sv
module spi_boot_rx #(
  parameter int NPIN    = 64,
  parameter int DEPTH   = 4,
  parameter int WAIT_HI = 3,
  parameter int WAIT_LO = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck,
  input  logic            cs_n,
  input  logic            mosi,
  input  logic            mem_rdy,
  output logic [NPIN-1:0] gpo,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [7:0]      mem_data,
  output logic            ovf_err
);
  localparam int LW   = $clog2(DEPTH + 1);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PIW  = (NPIN > 1) ? $clog2(NPIN) : 1;

  logic [2:0] sck_s;
  logic [1:0] cs_s, mosi_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s  <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      cs_s   <= {cs_s[0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
    end

  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire sel      = ~cs_s[1];

  logic [2:0] bcnt;
  logic [6:0] shreg;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bcnt  <= '0;
      shreg <= '0;
    end else if (!sel) begin
      bcnt <= '0;
    end else if (sck_rise) begin
      shreg <= {shreg[5:0], mosi_s[1]};
      bcnt  <= bcnt + 3'd1;
    end

  wire       byte_done = sel & sck_rise & (bcnt == 3'd7);
  wire [7:0] byte_val  = {shreg, mosi_s[1]};

  logic [7:0]      fifo [DEPTH];
  logic [PTRW-1:0] wp, rp;
  logic [LW-1:0]   lvl, lvl_nx;
  logic            wait_q, in_hdr;

  wire full = (lvl == LW'(DEPTH));
  wire push = byte_done & ~full;
  wire pop  = mem_rdy & (lvl != '0);

  always_comb begin
    lvl_nx = lvl;
    if (push && !pop) lvl_nx = lvl + LW'(1);
    if (pop && !push) lvl_nx = lvl - LW'(1);
  end

  always_ff @(posedge clk)
    if (push) fifo[wp] <= byte_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      lvl     <= '0;
      wait_q  <= 1'b0;
      ovf_err <= 1'b0;
    end else begin
      if (push) wp <= (wp == PTRW'(DEPTH - 1)) ? '0 : wp + PTRW'(1);
      if (pop)  rp <= (rp == PTRW'(DEPTH - 1)) ? '0 : rp + PTRW'(1);
      lvl <= lvl_nx;
      if (lvl_nx >= LW'(WAIT_HI))      wait_q <= 1'b1;
      else if (lvl_nx <= LW'(WAIT_LO)) wait_q <= 1'b0;
      if (byte_done && full) ovf_err <= 1'b1;
    end

  wire [7:0] head = fifo[rp];

  logic [3:0]     hidx;
  logic [31:0]    rem;
  logic [7:0]     flag_lo;
  logic [PIW-1:0] pin;
  wire  [15:0]    flag_w = {head, flag_lo};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_hdr   <= 1'b1;
      hidx     <= '0;
      mem_addr <= '0;
      rem      <= '0;
      flag_lo  <= '0;
      pin      <= '0;
    end else if (pop) begin
      if (in_hdr) begin
        if (hidx < 4'd4)      mem_addr[8*hidx[1:0] +: 8] <= head;
        else if (hidx < 4'd8) rem[8*hidx[1:0] +: 8]      <= head;
        else if (hidx == 4'd8) flag_lo <= head;
        else                   pin     <= flag_w[5 +: PIW];
        if (hidx == 4'd9) begin
          hidx   <= '0;
          in_hdr <= (rem == '0);
        end else begin
          hidx <= hidx + 4'd1;
        end
      end else begin
        mem_addr <= mem_addr + 32'd1;
        rem      <= rem - 32'd1;
        if (rem == 32'd1) in_hdr <= 1'b1;
      end
    end

  assign mem_we   = ~in_hdr & (lvl != '0);
  assign mem_data = head;
  assign gpo      = wait_q ? (NPIN'(1) << pin) : '0;
endmodule

// File: rtl/spi_boot_rx_chk.sv
module spi_boot_rx_chk #(
  parameter int NPIN    = 64,
  parameter int DEPTH   = 4,
  parameter int WAIT_HI = 3,
  parameter int WAIT_LO = 1,
  parameter int LW      = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] gpo,
  input logic            mem_we,
  input logic            mem_rdy,
  input logic [31:0]     mem_addr,
  input logic [7:0]      mem_data,
  input logic            ovf_err,
  input logic [LW-1:0]   lvl,
  input logic            wait_q
);
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpo) && (wait_q == (gpo != '0)));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LW'(DEPTH));
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  p_wait_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_q) |-> lvl >= LW'(WAIT_HI));
  p_wait_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_q) |-> lvl <= LW'(WAIT_LO));
  p_we_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_rdy) |=> (mem_we && $stable(mem_addr) && $stable(mem_data)));
endmodule

bind spi_boot_rx spi_boot_rx_chk #(
  .NPIN(NPIN), .DEPTH(DEPTH), .WAIT_HI(WAIT_HI), .WAIT_LO(WAIT_LO), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gpo(gpo), .mem_we(mem_we), .mem_rdy(mem_rdy),
  .mem_addr(mem_addr), .mem_data(mem_data), .ovf_err(ovf_err),
  .lvl(lvl), .wait_q(wait_q)
);

// File: tb/spi_boot_rx_tb.sv
module spi_boot_rx_tb;
  localparam int NPIN = 64;
  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0, mem_rdy = 0;
  logic [NPIN-1:0] gpo;
  logic mem_we, ovf_err;
  logic [31:0] mem_addr;
  logic [7:0] mem_data;

  spi_boot_rx #(.NPIN(NPIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .mem_rdy(mem_rdy), .gpo(gpo), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .ovf_err(ovf_err));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, nwr = 0;
  logic [31:0] wa [64];
  logic [7:0]  wd [64];
  always @(posedge clk)
    if (rst_n && mem_we && mem_rdy && nwr < 64) begin
      wa[nwr] <= mem_addr;
      wd[nwr] <= mem_data;
      nwr     <= nwr + 1;
    end

  // rows: {dest addr, count, pin}
  localparam logic [45:0] VEC [4] = '{
    {32'h2000_0000, 8'd5, 6'd12},
    {32'h0000_0FFE, 8'd1, 6'd63},
    {32'h1234_5678, 8'd0, 6'd40},
    {32'hFFFF_FFFE, 8'd4, 6'd7}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      repeat (3) @(negedge clk);
      sck = 1;
      repeat (3) @(negedge clk);
      sck = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [31:0] a, input logic [31:0] n, input logic [5:0] p);
    logic [15:0] f;
    f = {5'b10101, p, 5'b01011};
    for (int i = 0; i < 4; i++) spi_byte(a[8*i +: 8]);
    for (int i = 0; i < 4; i++) spi_byte(n[8*i +: 8]);
    spi_byte(f[7:0]);
    spi_byte(f[15:8]);
  endtask

  task automatic rdy_pulse();
    mem_rdy = 1;
    @(negedge clk);
    mem_rdy = 0;
    @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int base;
    logic [31:0] a;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk(gpo == '0 && !mem_we && !ovf_err, "R11 reset outputs", {gpo[31:0], 6'd0, mem_we, ovf_err}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: sck activity while deselected is ignored
    for (int i = 0; i < 5; i++) begin
      mosi = 1; repeat (3) @(negedge clk); sck = 1; repeat (3) @(negedge clk); sck = 0;
    end
    cs_n = 0;
    repeat (4) @(negedge clk);

    // R6 default pin 0, R4 threshold, with memory stalled
    spi_byte(8'h00); spi_byte(8'h01);
    chk(gpo == '0, "R4 level 2 no wait", gpo, 0);
    spi_byte(8'h00);
    chk(gpo == 64'h1, "R6 default pin 0", gpo, 1);
    @(negedge clk); mem_rdy = 1; repeat (3) @(negedge clk);
    chk(gpo == '0, "R4 released after drain", gpo, 0);
    spi_byte(8'h00);
    for (int i = 0; i < 4; i++) spi_byte(8'h00);
    spi_byte(8'h20); spi_byte(8'h01);
    repeat (4) @(negedge clk);
    chk(nwr == 0, "R9 zero count no write / R1 deselected ignored", nwr, 0);

    // table of blocks: R7 R8 R9
    foreach (VEC[r]) begin
      base = nwr;
      send_hdr(VEC[r][45:14], 32'(VEC[r][13:6]), VEC[r][5:0]);
      for (int k = 0; k < int'(VEC[r][13:6]); k++)
        spi_byte(VEC[r][21:14] + 8'(k * 37) + 8'(r));
      repeat (6) @(negedge clk);
      chk(nwr - base == int'(VEC[r][13:6]), "R8 R9 write count", nwr - base, VEC[r][13:6]);
      for (int k = 0; k < int'(VEC[r][13:6]); k++) begin
        a = VEC[r][45:14] + 32'(k);
        d = VEC[r][21:14] + 8'(k * 37) + 8'(r);
        chk(wa[base+k] == a && wd[base+k] == d, "R7 R8 addr/data", {wa[base+k], wd[base+k]}, {a, d});
      end
    end

    // hysteresis, pin select, stall hold, overflow: R3 R4 R5 R6 R10
    send_hdr(32'h0000_4000, 32'd8, 6'd33);
    repeat (4) @(negedge clk);
    mem_rdy = 0;
    base = nwr;
    spi_byte(8'hA1); spi_byte(8'hA2);
    chk(gpo == '0, "R4 level 2 no wait", gpo, 0);
    spi_byte(8'hA3);
    chk(gpo == (64'h1 << 33), "R6 R5 pin from flag bits 10:5", gpo, 64'h1 << 33);
    chk(mem_we && mem_addr == 32'h4000 && mem_data == 8'hA1, "R10 held while stalled", {mem_we, mem_addr, mem_data}, {1'b1, 32'h4000, 8'hA1});
    rdy_pulse();
    chk(gpo == (64'h1 << 33), "R4 hold at level 2", gpo, 64'h1 << 33);
    chk(nwr - base == 1, "R10 one byte per ready cycle", nwr - base, 1);
    rdy_pulse();
    chk(gpo == '0, "R4 release at level 1", gpo, 0);
    spi_byte(8'hA4);
    chk(gpo == '0, "R4 no rearm at level 2", gpo, 0);
    spi_byte(8'hA5); spi_byte(8'hA6);
    chk(gpo == (64'h1 << 33) && !ovf_err, "R3 stored while waiting", {gpo[33], ovf_err}, 2'b10);
    spi_byte(8'hA7);
    chk(ovf_err == 1'b1, "R3 overflow flagged", ovf_err, 1);
    mem_rdy = 1;
    repeat (6) @(negedge clk);
    spi_byte(8'hA8); spi_byte(8'hA9);
    repeat (4) @(negedge clk);
    chk(nwr - base == 8, "R3 dropped byte count", nwr - base, 8);
    for (int k = 0; k < 8; k++) begin
      d = (k < 6) ? 8'hA1 + 8'(k) : 8'hA2 + 8'(k);
      chk(wd[base+k] == d && wa[base+k] == 32'h4000 + 32'(k), "R3 only full-time byte lost", {wa[base+k], wd[base+k]}, {32'h4000 + 32'(k), d});
    end
    chk(ovf_err == 1'b1, "R3 sticky error", ovf_err, 1);

    // R2: partial byte discarded by chip select
    for (int i = 0; i < 3; i++) begin
      mosi = 1; repeat (3) @(negedge clk); sck = 1; repeat (3) @(negedge clk); sck = 0;
    end
    cs_n = 1; repeat (6) @(negedge clk); cs_n = 0; repeat (4) @(negedge clk);
    base = nwr;
    send_hdr(32'h0000_0777, 32'd1, 6'd2);
    spi_byte(8'h5C);
    repeat (4) @(negedge clk);
    chk(nwr - base == 1 && wa[base] == 32'h777 && wd[base] == 8'h5C, "R2 realigned after cs", {wa[base], wd[base]}, {32'h777, 8'h5C});

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule